// File: doc/BRIEF.md
# Prioritized Interrupt Node Controller

This block arbitrates among a set of maskable interrupt nodes and a small group of trap sources, and offers the winner to a CPU as a vector number. Each node owns a control register with a 4-bit priority level, an enable flag and a request flag. A peripheral raises a node's request with a one-cycle pulse, and software can set or clear the same flag through the register port. A node competes only when it is enabled, requesting, and its level is strictly above the CPU's current priority. Among the competitors the highest level wins, and on a tie the lower node index wins.

Trap sources sit outside the level scheme. Hardware trap lines and a non-maskable input (taken on its rising edge) always beat every node. A software trap request carries its own vector and is held in a single pending slot until it is serviced. The CPU sees `irq_valid` and `irq_vector` and answers with `irq_ack`. On an acknowledge the pending flag of the granted source is cleared at that clock edge, unless a new pulse for the same source arrives in the same cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every control register reads 0, no trap is pending, and `irq_valid` is 0.
- R2: A register word is 6 bits: level in bits [3:0], enable in bit 4, request in bit 5. A write to address n < NUM_NODES loads all three fields of node n, and a read returns them. An address at or above NUM_NODES reads 0, and a write to it changes no node.
- R3: A `src_pulse[n]` pulse sets the request flag of node n at the next edge. In that cycle the pulse wins over a clearing register write and over an acknowledge.
- R4: A node is eligible only if its request and enable flags are both 1 and its level is strictly greater than `cpu_prio`. With no trap pending and no node eligible, `irq_valid` is 0.
- R5: Among eligible nodes the highest level is granted, and equal levels go to the lower index. The vector of node n is NODE_VEC_BASE + n.
- R6: `irq_ack` while `irq_valid` is 1 clears the granted source's pending flag at that edge. `irq_ack` while `irq_valid` is 0 changes nothing.
- R7: A `hwtrap_in[i]` pulse latches a hardware trap. Any pending hardware trap is granted ahead of the NMI, the software trap and all nodes, regardless of `cpu_prio` or enable flags. The lowest pending index wins, with vector i.
- R8: A rising edge on `nmi_in` latches an NMI, which ranks below hardware traps and above the software trap and nodes, with vector NUM_HWTRAP. Holding `nmi_in` high raises only one NMI.
- R9: A `sw_trap_req` pulse with no software trap pending captures `sw_trap_vec`. The pending software trap outranks all nodes and ignores `cpu_prio`. A request made while one is already pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pulse | input | NUM_NODES | Per-node request pulses |
| hwtrap_in | input | NUM_HWTRAP | Hardware trap pulses |
| nmi_in | input | 1 | Non-maskable trap input, rising edge |
| sw_trap_req | input | 1 | Software trap request pulse |
| sw_trap_vec | input | VEC_W | Vector carried by the software trap |
| cpu_prio | input | 4 | Current CPU priority level |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (node index) |
| reg_wdata | input | 6 | Register write data |
| reg_rdata | output | 6 | Register read data |
| irq_valid | output | 1 | A source is being offered to the CPU |
| irq_vector | output | VEC_W | Vector of the offered source |
| irq_ack | input | 1 | CPU accepts the offered source |

## Verification
The bench uses the default parameters: 20 nodes, four hardware trap lines, 8-bit vectors and a node vector base of 16. The 5-bit address therefore includes the unmapped addresses 20 to 31, so the bench can check that out-of-range writes and reads have no effect. Four trap lines let it see the lowest-index order among hardware traps. The base of 16 keeps node vectors apart from trap vectors, so each check can tell which kind of source won.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int PRIO_W  = 4;
    localparam int CTRL_W  = 6;
    localparam int FLD_EN  = 4;
    localparam int FLD_REQ = 5;

    typedef enum logic [1:0] {
        SRC_HW   = 2'd0,
        SRC_NMI  = 2'd1,
        SRC_SW   = 2'd2,
        SRC_NODE = 2'd3
    } src_kind_e;
endpackage

// File: rtl/intc_node_bank.sv
module intc_node_bank
    import intc_pkg::*;
#(
    parameter int NUM_NODES = 20,
    localparam int ADDR_W = $clog2(NUM_NODES)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_NODES-1:0]             src_pulse,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [CTRL_W-1:0]                wr_data,
    input  logic [NUM_NODES-1:0]             ack_clr,
    output logic [NUM_NODES-1:0]             node_req,
    output logic [NUM_NODES-1:0]             node_en,
    output logic [NUM_NODES-1:0][PRIO_W-1:0] node_lvl
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_NODES - 1);

    typedef struct packed {
        logic [NUM_NODES-1:0]             req;
        logic [NUM_NODES-1:0]             en;
        logic [NUM_NODES-1:0][PRIO_W-1:0] lvl;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = st_q.req & ~ack_clr;
        if (wr_en && (wr_addr <= LAST_ADDR)) begin
            st_d.lvl[wr_addr] = wr_data[PRIO_W-1:0];
            st_d.en[wr_addr]  = wr_data[FLD_EN];
            st_d.req[wr_addr] = wr_data[FLD_REQ];
        end
        st_d.req = st_d.req | src_pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign node_req = st_q.req;
    assign node_en  = st_q.en;
    assign node_lvl = st_q.lvl;

    AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_pulse) |=> ((st_q.req & $past(src_pulse)) == $past(src_pulse))); // R3

    AST_ACK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(ack_clr & ~src_pulse)) && !wr_en)
        |=> ((st_q.req & $past(ack_clr & ~src_pulse)) == '0)); // R6

    AST_UNMAPPED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr > LAST_ADDR) && !(|src_pulse) && !(|ack_clr))
        |=> $stable(st_q)); // R2
endmodule

// File: rtl/intc_node_arb.sv
module intc_node_arb
    import intc_pkg::*;
#(
    parameter int NUM_NODES = 20,
    localparam int ADDR_W = $clog2(NUM_NODES)
) (
    input  logic [NUM_NODES-1:0]             node_req,
    input  logic [NUM_NODES-1:0]             node_en,
    input  logic [NUM_NODES-1:0][PRIO_W-1:0] node_lvl,
    input  logic [PRIO_W-1:0]                cpu_prio,
    output logic                             found,
    output logic [ADDR_W-1:0]                win_idx,
    output logic [PRIO_W-1:0]                win_lvl
);
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = cpu_prio;
        // Ascending scan with a strict compare keeps the lower index on ties.
        for (int i = 0; i < NUM_NODES; i++) begin
            if (node_req[i] && node_en[i] && (node_lvl[i] > win_lvl)) begin
                found   = 1'b1;
                win_idx = ADDR_W'(i);
                win_lvl = node_lvl[i];
            end
        end
    end
endmodule

// File: rtl/intc_trap_unit.sv
module intc_trap_unit #(
    parameter int NUM_HWTRAP = 4,
    parameter int VEC_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_HWTRAP-1:0] hw_pulse,
    input  logic                  nmi_in,
    input  logic                  sw_req,
    input  logic [VEC_W-1:0]      sw_vec,
    input  logic [NUM_HWTRAP-1:0] ack_hw,
    input  logic                  ack_nmi,
    input  logic                  ack_sw,
    output logic [NUM_HWTRAP-1:0] hw_pend,
    output logic                  nmi_pend,
    output logic                  sw_pend,
    output logic [VEC_W-1:0]      sw_vec_held
);
    typedef struct packed {
        logic [NUM_HWTRAP-1:0] hw;
        logic                  nmi;
        logic                  nmi_prev;
        logic                  sw;
        logic [VEC_W-1:0]      vec;
    } trap_t;

    trap_t tr_d, tr_q;

    always_comb begin
        tr_d          = tr_q;
        tr_d.hw       = (tr_q.hw & ~ack_hw) | hw_pulse;
        tr_d.nmi_prev = nmi_in;
        tr_d.nmi      = (tr_q.nmi & ~ack_nmi) | (nmi_in & ~tr_q.nmi_prev);
        tr_d.sw       = tr_q.sw & ~ack_sw;
        if (!tr_d.sw && sw_req) begin
            tr_d.sw  = 1'b1;
            tr_d.vec = sw_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tr_q <= '0;
        else        tr_q <= tr_d;
    end

    assign hw_pend     = tr_q.hw;
    assign nmi_pend    = tr_q.nmi;
    assign sw_pend     = tr_q.sw;
    assign sw_vec_held = tr_q.vec;

    AST_NMI_LEVEL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_nmi && tr_q.nmi_prev && nmi_in) |=> !tr_q.nmi); // R8

    AST_SW_SLOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_q.sw && !ack_sw) |=> (tr_q.sw && $stable(tr_q.vec))); // R9
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import intc_pkg::*;
#(
    parameter int NUM_NODES     = 20,
    parameter int NUM_HWTRAP    = 4,
    parameter int VEC_W         = 8,
    parameter int NODE_VEC_BASE = 16,
    localparam int ADDR_W = $clog2(NUM_NODES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_NODES-1:0]  src_pulse,
    input  logic [NUM_HWTRAP-1:0] hwtrap_in,
    input  logic                  nmi_in,
    input  logic                  sw_trap_req,
    input  logic [VEC_W-1:0]      sw_trap_vec,
    input  logic [PRIO_W-1:0]     cpu_prio,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [CTRL_W-1:0]     reg_wdata,
    output logic [CTRL_W-1:0]     reg_rdata,
    output logic                  irq_valid,
    output logic [VEC_W-1:0]      irq_vector,
    input  logic                  irq_ack
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_NODES - 1);

    logic [NUM_NODES-1:0]             node_req, node_en, ack_node;
    logic [NUM_NODES-1:0][PRIO_W-1:0] node_lvl;
    logic                             node_found;
    logic [ADDR_W-1:0]                win_idx;
    logic [PRIO_W-1:0]                win_lvl;
    logic [NUM_HWTRAP-1:0]            hw_pend, hw_sel, ack_hw;
    logic                             nmi_pend, sw_pend, ack_nmi, ack_sw, take;
    logic [VEC_W-1:0]                 sw_vec_held;
    src_kind_e                        sel_kind;

    intc_node_bank #(.NUM_NODES(NUM_NODES)) i_bank (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
        .wr_en(reg_we), .wr_addr(reg_addr), .wr_data(reg_wdata),
        .ack_clr(ack_node), .node_req(node_req), .node_en(node_en),
        .node_lvl(node_lvl)
    );

    intc_node_arb #(.NUM_NODES(NUM_NODES)) i_arb (
        .node_req(node_req), .node_en(node_en), .node_lvl(node_lvl),
        .cpu_prio(cpu_prio), .found(node_found), .win_idx(win_idx),
        .win_lvl(win_lvl)
    );

    intc_trap_unit #(.NUM_HWTRAP(NUM_HWTRAP), .VEC_W(VEC_W)) i_trap (
        .clk(clk), .rst_n(rst_n), .hw_pulse(hwtrap_in), .nmi_in(nmi_in),
        .sw_req(sw_trap_req), .sw_vec(sw_trap_vec), .ack_hw(ack_hw),
        .ack_nmi(ack_nmi), .ack_sw(ack_sw), .hw_pend(hw_pend),
        .nmi_pend(nmi_pend), .sw_pend(sw_pend), .sw_vec_held(sw_vec_held)
    );

    // Source selection: hardware traps, then NMI, then software trap, then nodes.
    always_comb begin
        sel_kind   = SRC_NODE;
        irq_valid  = 1'b0;
        irq_vector = '0;
        hw_sel     = '0;
        if (|hw_pend) begin
            sel_kind  = SRC_HW;
            irq_valid = 1'b1;
            for (int i = NUM_HWTRAP - 1; i >= 0; i--) begin
                if (hw_pend[i]) begin
                    hw_sel     = '0;
                    hw_sel[i]  = 1'b1;
                    irq_vector = VEC_W'(i);
                end
            end
        end else if (nmi_pend) begin
            sel_kind   = SRC_NMI;
            irq_valid  = 1'b1;
            irq_vector = VEC_W'(NUM_HWTRAP);
        end else if (sw_pend) begin
            sel_kind   = SRC_SW;
            irq_valid  = 1'b1;
            irq_vector = sw_vec_held;
        end else if (node_found) begin
            irq_valid  = 1'b1;
            irq_vector = VEC_W'(NODE_VEC_BASE) + VEC_W'(win_idx);
        end
    end

    // Acknowledge decode toward the granted source only.
    always_comb begin
        take     = irq_ack && irq_valid;
        ack_hw   = (take && (sel_kind == SRC_HW)) ? hw_sel : '0;
        ack_nmi  = take && (sel_kind == SRC_NMI);
        ack_sw   = take && (sel_kind == SRC_SW);
        ack_node = '0;
        for (int i = 0; i < NUM_NODES; i++) begin
            ack_node[i] = take && (sel_kind == SRC_NODE) && (win_idx == ADDR_W'(i));
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr <= LAST_ADDR) begin
            reg_rdata = {node_req[reg_addr], node_en[reg_addr], node_lvl[reg_addr]};
        end
    end

    AST_HW_TRAP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_pend) |-> (irq_valid && (irq_vector < VEC_W'(NUM_HWTRAP)))); // R7

    AST_NODE_ABOVE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && (sel_kind == SRC_NODE)) |-> (win_lvl > cpu_prio)); // R4

    AST_SINGLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_node, ack_hw, ack_nmi, ack_sw})); // R6
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
    localparam int  NN   = 20;
    localparam int  NH   = 4;
    localparam int  VW   = 8;
    localparam int  AW   = 5;
    localparam time TCLK = 8ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NN-1:0] src_pulse = '0;
    logic [NH-1:0] hwtrap_in = '0;
    logic          nmi_in = 1'b0;
    logic          sw_trap_req = 1'b0;
    logic [VW-1:0] sw_trap_vec = '0;
    logic [3:0]    cpu_prio = '0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [5:0]    reg_wdata = '0;
    logic [5:0]    reg_rdata;
    logic          irq_valid;
    logic [VW-1:0] irq_vector;
    logic          irq_ack = 1'b0;

    always #(TCLK/2) clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .hwtrap_in(hwtrap_in),
        .nmi_in(nmi_in), .sw_trap_req(sw_trap_req), .sw_trap_vec(sw_trap_vec),
        .cpu_prio(cpu_prio), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_valid(irq_valid),
        .irq_vector(irq_vector), .irq_ack(irq_ack)
    );

    typedef struct {
        string    req;
        int       kind;   // 0 valid, 1 vector, 2 read data
        int       expv;
    } item_t;

    item_t sb[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;

    // Monitor: compare queued expectations at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                int    act;
                it = sb.pop_front();
                case (it.kind)
                    0:       act = int'(irq_valid);
                    1:       act = int'(irq_vector);
                    default: act = int'(reg_rdata);
                endcase
                n_cmp++;
                if (act != it.expv) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h",
                             it.req, it.kind, act, it.expv);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic exp_out(string r, bit v, int vec);
        item_t it;
        it.req = r; it.kind = 0; it.expv = int'(v);
        sb.push_back(it);
        if (v) begin
            it.kind = 1; it.expv = vec;
            sb.push_back(it);
        end
        tick();
    endtask

    task automatic exp_rd(string r, int a, int e);
        item_t it;
        reg_addr = AW'(a);
        it.req = r; it.kind = 2; it.expv = e;
        sb.push_back(it);
        tick();
    endtask

    task automatic wr(int a, int d);
        reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = 6'(d);
        tick();
        reg_we = 1'b0;
    endtask

    task automatic pulse_src(int n);
        src_pulse[n] = 1'b1;
        tick();
        src_pulse = '0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(TCLK * 100000);
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        exp_out("R1", 1'b0, 0);
        exp_rd("R1", 0, 0);
        exp_rd("R1", 19, 0);

        // R2 register fields: level[3:0], enable bit4, request bit5
        wr(3, 'h15);
        exp_rd("R2", 3, 'h15);
        wr(7, 'h1A);
        exp_rd("R2", 7, 'h1A);
        wr(25, 'h3F);
        exp_rd("R2", 25, 0);
        exp_rd("R2", 9, 0);
        exp_out("R4", 1'b0, 0);

        // R3 pulse sets the flag; node 3 level 5 beats cpu 0 -> vector 19
        pulse_src(3);
        exp_rd("R3", 3, 'h35);
        exp_out("R5", 1'b1, 19);

        // R4 strict level compare against cpu_prio
        cpu_prio = 4'd5;
        exp_out("R4", 1'b0, 0);
        cpu_prio = 4'd4;
        exp_out("R4", 1'b1, 19);

        // R5 higher level wins, tie goes to lower index, disabled node ignored
        pulse_src(7);
        exp_out("R5", 1'b1, 23);
        wr(10, 'h3A);
        exp_out("R5", 1'b1, 23);
        wr(2, 'h2F);
        exp_out("R4", 1'b1, 23);

        // R6 ack clears the granted node only
        ack();
        exp_rd("R6", 7, 'h1A);
        exp_out("R6", 1'b1, 26);

        // R3 pulse in the ack cycle keeps the flag
        src_pulse[10] = 1'b1; irq_ack = 1'b1;
        tick();
        src_pulse = '0; irq_ack = 1'b0;
        exp_out("R3", 1'b1, 26);
        ack();
        exp_out("R6", 1'b1, 19);

        // R6 ack without a valid offer does nothing
        cpu_prio = 4'd15;
        exp_out("R6", 1'b0, 0);
        ack();
        cpu_prio = 4'd4;
        exp_out("R6", 1'b1, 19);

        // R7 hardware traps ignore cpu_prio, lowest index first
        cpu_prio = 4'd15;
        hwtrap_in = 4'b0100; tick(); hwtrap_in = '0;
        exp_out("R7", 1'b1, 2);
        hwtrap_in = 4'b0010; tick(); hwtrap_in = '0;
        exp_out("R7", 1'b1, 1);
        ack();
        exp_out("R7", 1'b1, 2);
        ack();
        exp_out("R7", 1'b0, 0);

        // R8 / R9 NMI above software trap, hardware trap above NMI
        cpu_prio = 4'd0;
        nmi_in = 1'b1; sw_trap_req = 1'b1; sw_trap_vec = 8'h55;
        tick();
        sw_trap_req = 1'b0;
        exp_out("R8", 1'b1, 4);
        hwtrap_in = 4'b1000; tick(); hwtrap_in = '0;
        exp_out("R7", 1'b1, 3);
        ack();
        exp_out("R8", 1'b1, 4);
        ack();
        exp_out("R8", 1'b1, 'h55);
        sw_trap_req = 1'b1; sw_trap_vec = 8'h66;
        tick();
        sw_trap_req = 1'b0;
        exp_out("R9", 1'b1, 'h55);
        ack();
        exp_out("R9", 1'b1, 19);
        nmi_in = 1'b0; tick();
        nmi_in = 1'b1; tick();
        exp_out("R8", 1'b1, 4);
        ack();
        exp_out("R8", 1'b1, 19);

        // R2 / R3 software clear, and pulse winning over a clearing write
        wr(3, 'h15);
        exp_rd("R2", 3, 'h15);
        exp_out("R4", 1'b0, 0);
        src_pulse[3] = 1'b1;
        wr(3, 'h15);
        src_pulse = '0;
        exp_rd("R3", 3, 'h35);
        exp_out("R3", 1'b1, 19);

        tick();
        tick();
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule